// File: doc/BRIEF.md
# Bridge I/O Routing Decoder

This block sits on the downstream side of a root-port bridge and picks a destination for each I/O or memory request that the processor issues: either the PCI Express port below the bridge or the legacy south link. A request is presented for one cycle with its address, a flag marking it as I/O or memory, and a valid strobe. One cycle later the block returns a registered verdict as a one-hot pair of destination flags. Addresses that no decoded range claims go to the legacy link.

The verdict depends on a small set of configuration registers written through a simple config port. The first is a control register with four enables: VGA decode, ISA alias, upstream error forwarding and poisoned-packet reporting. The other two hold the bottom and top of the I/O window in 4KB units. With ISA alias enabled, every 1KB block inside the window keeps only its first 256 bytes for the port. The upper 768 bytes of each block go to the legacy link. VGA decode claims the VGA memory aperture and the VGA I/O ports for the port, whatever the ISA alias and window settings are.

The block also filters traffic heading upstream from the port. It passes correctable, non-fatal and fatal error messages only while forwarding is enabled. It raises a poisoned-packet report only while reporting is enabled.

Top module: `bio_router_top`

## Requirements
- R1: After reset the control register reads 0x00, the window bottom register reads 0x0F, the window top register reads 0x00 (so the window is empty), and `rt_valid`, `rt_to_pcie`, `rt_to_legacy`, `up_err_valid` and `poison_rpt` are 0.
- R2: A write with `cfg_wr`=1 updates the register at `cfg_addr`. At address 0, bit 0 is poison reporting enable, bit 1 is error forwarding enable, bit 2 is ISA alias enable and bit 3 is VGA decode enable. Address 1 bits [3:0] hold the window bottom (I/O address bits [15:12]). Address 2 bits [3:0] hold the window top. `cfg_rdata` shows the addressed register combinationally, with unused bits and address 3 reading 0.
- R3: The cycle after a cycle with `txn_valid`=1, `rt_valid` is 1 and exactly one of `rt_to_pcie`/`rt_to_legacy` is 1. After a cycle with `txn_valid`=0, all three are 0.
- R4: With ISA alias off, an I/O request whose address bits [31:16] are zero and whose bits [15:12] lie between window bottom and top inclusive goes to PCI Express. This means the window spans bottom×4KB up to top×4KB+0xFFF.
- R5: With ISA alias on, an I/O request inside the window whose address bits [9:8] are non-zero goes to the legacy link, and one with bits [9:8]=00 goes to PCI Express.
- R6: An I/O request outside the window, or with any of address bits [31:16] set, and a memory request outside the VGA aperture, go to the legacy link unless R7 claims them.
- R7: With VGA decode on, memory requests to 0xA0000–0xBFFFF and I/O requests to 0x3B0–0x3BB and 0x3C0–0x3DF go to PCI Express regardless of ISA alias and window. With VGA decode off, these addresses get no special treatment.
- R8: An error message presented with `err_valid`=1 and `err_sev` of 0 (correctable), 1 (non-fatal) or 2 (fatal) appears on `up_err_valid`/`up_err_sev` the next cycle only while error forwarding is enabled. Code 3 is never forwarded.
- R9: `poison_rpt` pulses the cycle after `poison_in` only while poison reporting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config register select |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data |
| txn_valid | input | 1 | Request strobe |
| txn_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| txn_addr | input | 32 | Request address |
| rt_valid | output | 1 | Routing verdict valid |
| rt_to_pcie | output | 1 | Request goes to PCI Express port |
| rt_to_legacy | output | 1 | Request goes to legacy south link |
| err_valid | input | 1 | Error message from port |
| err_sev | input | 2 | Error severity code |
| up_err_valid | output | 1 | Error message forwarded upstream |
| up_err_sev | output | 2 | Forwarded severity code |
| poison_in | input | 1 | Poisoned packet seen on port |
| poison_rpt | output | 1 | Poisoned packet report |

## Verification
The bench probes both edges of the 4KB window (0x0FFF, 0x1000, 0x2FFF, 0x3000). A design with an off-by-one compare or with the limit's low bits taken as zero would misroute one of these. It walks the ISA alias across each quarter boundary of a 1KB block (0x10FF/0x1100, 0x13FF/0x1400), which catches a decoder that tests the wrong address bits. It checks VGA ports that sit in an ISA hole and the addresses just past each VGA range, so VGA priority that is missing or ranges that are too wide both show. It also sends the reserved severity code and traffic with each enable off, to catch gates that leak.

// File: rtl/bio_pkg.sv
package bio_pkg;

    localparam int CFG_AW = 2;
    localparam int CFG_DW = 8;

    localparam logic [CFG_AW-1:0] REG_CTRL  = 2'd0;
    localparam logic [CFG_AW-1:0] REG_WBOT  = 2'd1;
    localparam logic [CFG_AW-1:0] REG_WTOP  = 2'd2;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_RSVD     = 2'd3
    } err_sev_e;

    // bit 3..0 of the control register
    typedef struct packed {
        logic vga_en;
        logic isa_en;
        logic fwd_en;
        logic poison_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/bio_cfg_regs.sv
module bio_cfg_regs
    import bio_pkg::*;
#(
    parameter int WIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output logic [CFG_DW-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [WIN_W-1:0]  win_bot,
    output logic [WIN_W-1:0]  win_top
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [WIN_W-1:0] bot;
        logic [WIN_W-1:0] top;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: '0, bot: '1, top: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                REG_CTRL: regs_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                REG_WBOT: regs_d.bot  = wdata[WIN_W-1:0];
                REG_WTOP: regs_d.top  = wdata[WIN_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: rdata[CTRL_W-1:0] = regs_q.ctrl;
            REG_WBOT: rdata[WIN_W-1:0]  = regs_q.bot;
            REG_WTOP: rdata[WIN_W-1:0]  = regs_q.top;
            default:  rdata = '0;
        endcase
    end

    assign ctrl    = regs_q.ctrl;
    assign win_bot = regs_q.bot;
    assign win_top = regs_q.top;

    // R2: a written control value is visible the following cycle
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL) |=> (ctrl == ctrl_t'($past(wdata[CTRL_W-1:0]))));

    // R2: no write leaves the window registers unchanged
    assert_win_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(win_bot) && $stable(win_top)));

endmodule

// File: rtl/bio_route_dec.sv
module bio_route_dec
    import bio_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_AW  = 16,
    parameter int GRAN_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  ctrl_t                   ctrl,
    input  logic [IO_AW-GRAN_W-1:0] win_bot,
    input  logic [IO_AW-GRAN_W-1:0] win_top,
    input  logic                    txn_valid,
    input  logic                    txn_is_io,
    input  logic [ADDR_W-1:0]       txn_addr,
    output logic                    rt_valid,
    output logic                    rt_to_pcie,
    output logic                    rt_to_legacy
);

    localparam int WIN_W = IO_AW - GRAN_W;
    localparam logic [IO_AW-1:0]  VGA_IO0_LO = IO_AW'(16'h03B0);
    localparam logic [IO_AW-1:0]  VGA_IO0_HI = IO_AW'(16'h03BB);
    localparam logic [IO_AW-1:0]  VGA_IO1_LO = IO_AW'(16'h03C0);
    localparam logic [IO_AW-1:0]  VGA_IO1_HI = IO_AW'(16'h03DF);
    localparam logic [ADDR_W-1:0] VGA_MEM_LO = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] VGA_MEM_HI = ADDR_W'(32'h000B_FFFF);

    typedef struct packed {
        logic valid;
        logic pcie;
        logic legacy;
    } verdict_t;

    verdict_t v_d, v_q;

    logic             io_space_ok;
    logic [IO_AW-1:0] io_off;
    logic [WIN_W-1:0] io_page;
    logic             in_window;
    logic             isa_hole;
    logic             vga_io_hit;
    logic             vga_mem_hit;
    logic             claim;

    always_comb begin
        io_space_ok = (txn_addr[ADDR_W-1:IO_AW] == '0);
        io_off      = txn_addr[IO_AW-1:0];
        io_page     = txn_addr[IO_AW-1:GRAN_W];
        in_window   = io_space_ok && (io_page >= win_bot) && (io_page <= win_top);
        isa_hole    = ctrl.isa_en && (txn_addr[9:8] != 2'b00);
        vga_io_hit  = io_space_ok &&
                      (((io_off >= VGA_IO0_LO) && (io_off <= VGA_IO0_HI)) ||
                       ((io_off >= VGA_IO1_LO) && (io_off <= VGA_IO1_HI)));
        vga_mem_hit = (txn_addr >= VGA_MEM_LO) && (txn_addr <= VGA_MEM_HI);

        if (txn_is_io)
            claim = (ctrl.vga_en && vga_io_hit) || (in_window && !isa_hole);
        else
            claim = ctrl.vga_en && vga_mem_hit;

        v_d        = '0;
        v_d.valid  = txn_valid;
        v_d.pcie   = txn_valid && claim;
        v_d.legacy = txn_valid && !claim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign rt_valid     = v_q.valid;
    assign rt_to_pcie   = v_q.pcie;
    assign rt_to_legacy = v_q.legacy;

    // R3: a verdict carries exactly one destination
    assert_onehot_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> ($countones({rt_to_pcie, rt_to_legacy}) == 1));

    // R3: verdict follows a request by one cycle
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> rt_valid);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_valid |-> (!rt_to_pcie && !rt_to_legacy));

    // R7: memory goes to the port only through VGA decode
    assert_mem_needs_vga_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_is_io && !ctrl.vga_en) |=> !rt_to_pcie);

    // R5: an ISA hole reaches the port only through VGA decode
    assert_isa_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_is_io && ctrl.isa_en && !ctrl.vga_en && txn_addr[9:8] != 2'b00)
        |=> rt_to_legacy);

endmodule

// File: rtl/bio_err_gate.sv
module bio_err_gate
    import bio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctrl_t      ctrl,
    input  logic       err_valid,
    input  logic [1:0] err_sev,
    input  logic       poison_in,
    output logic       up_err_valid,
    output logic [1:0] up_err_sev,
    output logic       poison_rpt
);

    typedef struct packed {
        logic     err_vld;
        err_sev_e sev;
        logic     poison;
    } gate_t;

    gate_t g_d, g_q;
    err_sev_e sev_in;

    always_comb begin
        sev_in    = err_sev_e'(err_sev);
        g_d       = '0;
        g_d.sev   = SEV_COR;
        if (err_valid && ctrl.fwd_en && sev_in != SEV_RSVD) begin
            g_d.err_vld = 1'b1;
            g_d.sev     = sev_in;
        end
        g_d.poison = poison_in && ctrl.poison_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{err_vld: 1'b0, sev: SEV_COR, poison: 1'b0};
        else        g_q <= g_d;
    end

    assign up_err_valid = g_q.err_vld;
    assign up_err_sev   = g_q.sev;
    assign poison_rpt   = g_q.poison;

    // R8: forwarding disabled means nothing upstream
    assert_fwd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.fwd_en |=> !up_err_valid);

    assert_no_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_err_valid |-> (up_err_sev != 2'd3));

    // R9: a report needs a poisoned packet and the enable
    assert_poison_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        poison_rpt |-> $past(poison_in && ctrl.poison_en));

endmodule

// File: rtl/bio_router_top.sv
module bio_router_top
    import bio_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_AW  = 16,
    parameter int GRAN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              txn_valid,
    input  logic              txn_is_io,
    input  logic [ADDR_W-1:0] txn_addr,
    output logic              rt_valid,
    output logic              rt_to_pcie,
    output logic              rt_to_legacy,
    input  logic              err_valid,
    input  logic [1:0]        err_sev,
    output logic              up_err_valid,
    output logic [1:0]        up_err_sev,
    input  logic              poison_in,
    output logic              poison_rpt
);

    localparam int WIN_W = IO_AW - GRAN_W;

    ctrl_t            ctrl;
    logic [WIN_W-1:0] win_bot;
    logic [WIN_W-1:0] win_top;

    bio_cfg_regs #(.WIN_W(WIN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .ctrl    (ctrl),
        .win_bot (win_bot),
        .win_top (win_top)
    );

    bio_route_dec #(.ADDR_W(ADDR_W), .IO_AW(IO_AW), .GRAN_W(GRAN_W)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .win_bot      (win_bot),
        .win_top      (win_top),
        .txn_valid    (txn_valid),
        .txn_is_io    (txn_is_io),
        .txn_addr     (txn_addr),
        .rt_valid     (rt_valid),
        .rt_to_pcie   (rt_to_pcie),
        .rt_to_legacy (rt_to_legacy)
    );

    bio_err_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .err_valid    (err_valid),
        .err_sev      (err_sev),
        .poison_in    (poison_in),
        .up_err_valid (up_err_valid),
        .up_err_sev   (up_err_sev),
        .poison_rpt   (poison_rpt)
    );

endmodule

// File: tb/tb_bio_router_top.sv
module tb_bio_router_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        txn_valid = 1'b0;
    logic        txn_is_io = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        rt_valid, rt_to_pcie, rt_to_legacy;
    logic        err_valid = 1'b0;
    logic [1:0]  err_sev = '0;
    logic        up_err_valid;
    logic [1:0]  up_err_sev;
    logic        poison_in = 1'b0;
    logic        poison_rpt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bio_router_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .txn_valid(txn_valid), .txn_is_io(txn_is_io), .txn_addr(txn_addr),
        .rt_valid(rt_valid), .rt_to_pcie(rt_to_pcie), .rt_to_legacy(rt_to_legacy),
        .err_valid(err_valid), .err_sev(err_sev),
        .up_err_valid(up_err_valid), .up_err_sev(up_err_sev),
        .poison_in(poison_in), .poison_rpt(poison_rpt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_expect(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, 32'(cfg_rdata), 32'(exp), $sformatf("rdata@%0d", a));
    endtask

    // present one request, check the verdict one cycle later
    task automatic route(input logic io, input logic [31:0] a, input logic exp_pcie,
                         input string req);
        @(negedge clk);
        txn_valid = 1'b1; txn_is_io = io; txn_addr = a;
        @(negedge clk);
        txn_valid = 1'b0;
        check(req, {29'd0, rt_valid, rt_to_pcie, rt_to_legacy},
              {29'd0, 1'b1, exp_pcie, !exp_pcie},
              $sformatf("%s 0x%0h {valid,pcie,legacy}", io ? "io" : "mem", a));
    endtask

    task automatic send_err(input logic [1:0] sev, input logic exp_fwd, input string req);
        @(negedge clk);
        err_valid = 1'b1; err_sev = sev;
        @(negedge clk);
        err_valid = 1'b0;
        check(req, {29'd0, up_err_valid, exp_fwd ? up_err_sev : 2'd0},
              {29'd0, exp_fwd, exp_fwd ? sev : 2'd0}, $sformatf("err sev %0d", sev));
    endtask

    task automatic send_poison(input logic exp_rpt, input string req);
        @(negedge clk);
        poison_in = 1'b1;
        @(negedge clk);
        poison_in = 1'b0;
        check(req, 32'(poison_rpt), 32'(exp_rpt), "poison_rpt");
    endtask

    task automatic t_reset;
        cfg_expect(2'd0, 8'h00, "R1");
        cfg_expect(2'd1, 8'h0F, "R1");
        cfg_expect(2'd2, 8'h00, "R1");
        check("R1", {28'd0, rt_valid, rt_to_pcie, rt_to_legacy, up_err_valid}, 32'd0, "outputs");
        check("R1", 32'(poison_rpt), 32'd0, "poison_rpt");
        // empty window: a low I/O address goes to legacy
        route(1'b1, 32'h0000_0100, 1'b0, "R1");
    endtask

    task automatic t_cfg;
        cfg_write(2'd0, 8'hFA);
        cfg_expect(2'd0, 8'h0A, "R2");
        cfg_write(2'd1, 8'hF1);
        cfg_expect(2'd1, 8'h01, "R2");
        cfg_write(2'd2, 8'h02);
        cfg_expect(2'd2, 8'h02, "R2");
        cfg_write(2'd3, 8'hFF);
        cfg_expect(2'd3, 8'h00, "R2");
        cfg_write(2'd0, 8'h00);
        cfg_expect(2'd0, 8'h00, "R2");
    endtask

    task automatic t_window;
        route(1'b1, 32'h0000_1000, 1'b1, "R4");
        route(1'b1, 32'h0000_2FFF, 1'b1, "R4");
        route(1'b1, 32'h0000_1300, 1'b1, "R4");
        route(1'b1, 32'h0000_0FFF, 1'b0, "R6");
        route(1'b1, 32'h0000_3000, 1'b0, "R6");
        route(1'b1, 32'h0001_1000, 1'b0, "R6");
        route(1'b0, 32'h0000_1000, 1'b0, "R6");
        // idle after the last request
        @(negedge clk);
        check("R3", {29'd0, rt_valid, rt_to_pcie, rt_to_legacy}, 32'd0, "idle");
    endtask

    task automatic t_isa;
        cfg_write(2'd0, 8'h04);
        route(1'b1, 32'h0000_1000, 1'b1, "R5");
        route(1'b1, 32'h0000_10FF, 1'b1, "R5");
        route(1'b1, 32'h0000_1100, 1'b0, "R5");
        route(1'b1, 32'h0000_1200, 1'b0, "R5");
        route(1'b1, 32'h0000_13FF, 1'b0, "R5");
        route(1'b1, 32'h0000_1400, 1'b1, "R5");
        route(1'b1, 32'h0000_2C00, 1'b1, "R5");
        route(1'b1, 32'h0000_0000, 1'b0, "R6");
    endtask

    task automatic t_vga;
        // VGA decode off: no claim
        route(1'b1, 32'h0000_03C0, 1'b0, "R7");
        route(1'b0, 32'h000A_0000, 1'b0, "R7");
        cfg_write(2'd0, 8'h0C);
        route(1'b1, 32'h0000_03B0, 1'b1, "R7");
        route(1'b1, 32'h0000_03BB, 1'b1, "R7");
        route(1'b1, 32'h0000_03BC, 1'b0, "R7");
        route(1'b1, 32'h0000_03BF, 1'b0, "R7");
        route(1'b1, 32'h0000_03C0, 1'b1, "R7");
        route(1'b1, 32'h0000_03DF, 1'b1, "R7");
        route(1'b1, 32'h0000_03E0, 1'b0, "R7");
        route(1'b1, 32'h0001_03C0, 1'b0, "R7");
        route(1'b0, 32'h000A_0000, 1'b1, "R7");
        route(1'b0, 32'h000B_FFFF, 1'b1, "R7");
        route(1'b0, 32'h0009_FFFF, 1'b0, "R7");
        route(1'b0, 32'h000C_0000, 1'b0, "R7");
        route(1'b0, 32'h000A_03C0, 1'b1, "R7");
        route(1'b1, 32'h0000_1100, 1'b0, "R5");
    endtask

    task automatic t_err;
        cfg_write(2'd0, 8'h00);
        send_err(2'd0, 1'b0, "R8");
        send_err(2'd2, 1'b0, "R8");
        cfg_write(2'd0, 8'h02);
        send_err(2'd0, 1'b1, "R8");
        send_err(2'd1, 1'b1, "R8");
        send_err(2'd2, 1'b1, "R8");
        send_err(2'd3, 1'b0, "R8");
        send_poison(1'b0, "R9");
    endtask

    task automatic t_poison;
        cfg_write(2'd0, 8'h01);
        send_poison(1'b1, "R9");
        @(negedge clk);
        check("R9", 32'(poison_rpt), 32'd0, "poison pulse ends");
        send_err(2'd1, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        cfg_write(2'd1, 8'h01);
        cfg_write(2'd2, 8'h02);
        t_window();
        t_isa();
        t_vga();
        t_err();
        t_poison();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule